// File: doc/BRIEF.md
# Non-linear horizontal video resampler

This block resamples one video line at a time along the horizontal axis. Pixels arrive as a valid-qualified stream, and a sync pulse marks the start of each line. They are written into a small dual-port line store. A phase generator walks an output position across that store. For every output pixel it interpolates linearly between the two nearest stored samples. The step between output positions sets the local scale: a step of 1.0 copies the input, smaller steps zoom and larger steps decimate. The step is kept between 0.25 and 4.0 input samples per output pixel, which gives overall ratios from 4 down to 0.25.

In uniform mode the step never changes. In the two shaped modes a signed delta is added to the step after every output pixel, and its sign flips at a programmed centre count, so the step follows a parabolic profile across the line.

- **Widescreen-fill mode** starts with a small step, so the left border is stretched. The step grows towards the centre, which is squeezed. It then shrinks again, so the right border is stretched too. This fills a wide screen from a narrower picture.
- **Narrow-fill mode** applies the opposite profile. It shows a wide picture on a narrower screen by distorting the borders, without cropping.

Fixed sample-rate conversions are uniform mode with a constant step. A step of 0xAAAB gives about 1.5 output pixels per input pixel, and 0xCCCD gives about 1.25.

The store decouples the two rates. When the sample that the next output needs has not yet arrived, output simply pauses. A line ends once the output position reaches the last input sample of the programmed line length.

Top module: `hs_scaler`

## Requirements
- R1: After reset, out_valid is low, and it stays low until a line has been started with in_sync and filled with input pixels.
- R2: The output position is fixed point with a 16-bit fraction. At sync it loads an integer part of 0 and a fraction of cfg_start_phase, and it advances by the current step after each output pixel. For an output pixel whose position has integer part i and top six fraction bits w, every 8-bit component of in_pix (bits [8k+7:8k]) is output as (s[i]*(64-w) + s[i+1]*w) >> 6, where s is the input sample sequence of the line.
- R3: Output pixels are produced only while i+1 < L, where L is cfg_in_len latched at sync and i is the integer part of the output position. After that, the line produces no more output.
- R4: With cfg_mode = 1 (widescreen fill), after output pixel n (counting from 0) the step grows by cfg_delta when n < cfg_half, and shrinks by cfg_delta otherwise.
- R5: With cfg_mode = 2 (narrow fill), after output pixel n the step shrinks by cfg_delta when n < cfg_half, and grows by cfg_delta otherwise.
- R6: The step is clamped to the range 0x4000 to 0x40000 (0.25 to 4.0). This applies both to the loaded cfg_start_inc and after every delta update.
- R7: An output pixel at integer position i is issued only after input sample i+1 has been written. The output values do not depend on how the input pixels are paced.
- R8: in_sync restarts the line. The write index goes back to sample 0, and the position, the step, the output count and the configuration are reloaded. No output from the previous line follows the restart, once the pipeline (up to two pixels) has drained.
- R9: With cfg_mode = 0 or 3 the step stays equal to the loaded start step, whatever the value of cfg_delta.
- R10: With a 41-sample line, start phase 0 and uniform mode, a step of 0xAAAB yields 60 output pixels and a step of 0xCCCD yields 50.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 0 uniform, 1 widescreen fill, 2 narrow fill, 3 uniform |
| cfg_start_inc | input | 19 | Start step in input samples per output pixel, 16-bit fraction |
| cfg_start_phase | input | 16 | Fractional start position |
| cfg_delta | input | 16 | Signed step change applied per output pixel in the shaped modes |
| cfg_half | input | 12 | Output count at which the delta changes sign |
| cfg_in_len | input | 12 | Number of input samples in the line |
| in_sync | input | 1 | Line start pulse |
| in_valid | input | 1 | Input pixel qualifier |
| in_pix | input | 24 | Input pixel, three 8-bit components |
| out_valid | output | 1 | Output pixel qualifier |
| out_pix | output | 24 | Output pixel, three 8-bit components |

## Verification
Each component of the input lines follows a different curve: a rising ramp, a falling ramp and a square. A wrong weight direction or a wrong component placement therefore shows up as a value error. A unit step separates plain copying from a half step and from a quarter-rate decimation, and a start phase of one half shows whether the weight is taken from the fraction. The shaped modes are run with a small delta, a delta large enough to hit both clamp limits, and a reserved mode code with a nonzero delta. Together these show whether the step changes direction at the centre count and whether the delta is ignored in uniform mode. A slowly paced input and a line cut short by a new sync show that output waits for data and restarts cleanly.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    HS_UNIFORM = 2'd0,
    HS_WIDE    = 2'd1,
    HS_NARROW  = 2'd2,
    HS_RSVD    = 2'd3
  } hs_mode_e;

  localparam int WT_BITS = 6;
endpackage

// File: rtl/hs_line_ram.sv
module hs_line_ram #(
  parameter int DW = 24,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hs_phase_gen.sv
module hs_phase_gen
  import hs_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int FRAC    = 16,
  parameter int INC_W   = 19,
  parameter int DELTA_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sync,
  input  logic [CNT_W-1:0]          wr_count,
  input  logic [1:0]                cfg_mode,
  input  logic [INC_W-1:0]          cfg_start_inc,
  input  logic [FRAC-1:0]           cfg_start_phase,
  input  logic signed [DELTA_W-1:0] cfg_delta,
  input  logic [CNT_W-1:0]          cfg_half,
  input  logic [CNT_W-1:0]          cfg_in_len,
  output logic                      issue,
  output logic                      active,
  output logic [CNT_W-1:0]          rd_idx,
  output logic [WT_BITS-1:0]        weight,
  output logic [INC_W-1:0]          cur_inc,
  output logic [CNT_W-1:0]          len_q,
  output logic [1:0]                mode_q
);
  localparam int ACC_W = CNT_W + FRAC;
  localparam int SW    = INC_W + 2;
  localparam logic signed [SW-1:0] MIN_INC = SW'(1 << (FRAC - 2));
  localparam logic signed [SW-1:0] MAX_INC = SW'(4 << FRAC);

  logic [ACC_W-1:0]          acc;
  logic [CNT_W-1:0]          out_cnt;
  logic [CNT_W-1:0]          half_q;
  logic signed [DELTA_W-1:0] delta_q;
  logic signed [SW-1:0]      step_ext;
  logic signed [SW-1:0]      raw_inc;
  logic [INC_W-1:0]          next_inc;
  logic                      have_room;
  logic                      data_ok;
  logic                      before_mid;

  function automatic logic [INC_W-1:0] clamp_inc(input logic signed [SW-1:0] v);
    if (v < MIN_INC)      clamp_inc = INC_W'(MIN_INC);
    else if (v > MAX_INC) clamp_inc = INC_W'(MAX_INC);
    else                  clamp_inc = INC_W'(v);
  endfunction

  assign rd_idx = acc[ACC_W-1:FRAC];
  assign weight = acc[FRAC-1 -: WT_BITS];

  assign have_room = ({1'b0, rd_idx} + (CNT_W+1)'(1)) < {1'b0, len_q};
  assign data_ok   = {1'b0, wr_count} >= ({1'b0, rd_idx} + (CNT_W+1)'(2));
  assign issue     = active && !sync && have_room && data_ok;

  assign before_mid = out_cnt < half_q;
  assign step_ext   = SW'(delta_q);

  always_comb begin
    case (mode_q)
      HS_WIDE:   raw_inc = $signed({2'b00, cur_inc}) + (before_mid ? step_ext : -step_ext);
      HS_NARROW: raw_inc = $signed({2'b00, cur_inc}) + (before_mid ? -step_ext : step_ext);
      default:   raw_inc = $signed({2'b00, cur_inc});
    endcase
    next_inc = clamp_inc(raw_inc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      acc     <= '0;
      cur_inc <= INC_W'(MIN_INC);
      out_cnt <= '0;
      len_q   <= '0;
      half_q  <= '0;
      delta_q <= '0;
      mode_q  <= HS_UNIFORM;
    end else if (sync) begin
      active  <= 1'b1;
      acc     <= {{CNT_W{1'b0}}, cfg_start_phase};
      cur_inc <= clamp_inc($signed({2'b00, cfg_start_inc}));
      out_cnt <= '0;
      len_q   <= cfg_in_len;
      half_q  <= cfg_half;
      delta_q <= cfg_delta;
      mode_q  <= cfg_mode;
    end else if (active) begin
      if (!have_room) begin
        active <= 1'b0;
      end else if (data_ok) begin
        acc     <= acc + ACC_W'(cur_inc);
        cur_inc <= next_inc;
        out_cnt <= out_cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/hs_lerp.sv
module hs_lerp
  import hs_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NCOMP = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [NCOMP*DW-1:0]   left_pix,
  input  logic [NCOMP*DW-1:0]   right_pix,
  input  logic [WT_BITS-1:0]    weight,
  output logic                  out_valid,
  output logic [NCOMP*DW-1:0]   out_pix
);
  localparam int SUM_W = DW + WT_BITS + 1;

  logic [WT_BITS:0] w_right;
  logic [WT_BITS:0] w_left;

  assign w_right = {1'b0, weight};
  assign w_left  = (WT_BITS+1)'(1 << WT_BITS) - w_right;

  genvar k;
  generate
    for (k = 0; k < NCOMP; k++) begin : g_comp
      logic [SUM_W-1:0] sum;
      assign sum = SUM_W'(left_pix[k*DW +: DW]) * SUM_W'(w_left)
                 + SUM_W'(right_pix[k*DW +: DW]) * SUM_W'(w_right);
      always_ff @(posedge clk) begin
        if (rst) out_pix[k*DW +: DW] <= '0;
        else     out_pix[k*DW +: DW] <= sum[WT_BITS +: DW];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end
endmodule

// File: rtl/hs_scaler.sv
module hs_scaler
  import hs_pkg::*;
#(
  parameter int DW      = 8,
  parameter int NCOMP   = 3,
  parameter int AW      = 9,
  parameter int CNT_W   = 12,
  parameter int FRAC    = 16,
  parameter int INC_W   = 19,
  parameter int DELTA_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [1:0]                cfg_mode,
  input  logic [INC_W-1:0]          cfg_start_inc,
  input  logic [FRAC-1:0]           cfg_start_phase,
  input  logic signed [DELTA_W-1:0] cfg_delta,
  input  logic [CNT_W-1:0]          cfg_half,
  input  logic [CNT_W-1:0]          cfg_in_len,
  input  logic                      in_sync,
  input  logic                      in_valid,
  input  logic [NCOMP*DW-1:0]       in_pix,
  output logic                      out_valid,
  output logic [NCOMP*DW-1:0]       out_pix
);
  localparam int PW = NCOMP * DW;

  logic [CNT_W-1:0]   wr_count;
  logic [AW-1:0]      waddr;
  logic               issue;
  logic               active;
  logic [CNT_W-1:0]   rd_idx;
  logic [WT_BITS-1:0] weight;
  logic [INC_W-1:0]   cur_inc;
  logic [CNT_W-1:0]   len_q;
  logic [1:0]         mode_q;
  logic               rd_valid;
  logic [WT_BITS-1:0] rd_weight;
  logic [PW-1:0]      bank_q [2];

  // Write side: a sync that carries a pixel places it at index 0.
  assign waddr = in_sync ? '0 : wr_count[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst)           wr_count <= '0;
    else if (in_sync)  wr_count <= in_valid ? CNT_W'(1) : '0;
    else if (in_valid) wr_count <= wr_count + CNT_W'(1);
  end

  hs_phase_gen #(
    .CNT_W(CNT_W), .FRAC(FRAC), .INC_W(INC_W), .DELTA_W(DELTA_W)
  ) u_phase (
    .clk(clk), .rst(rst), .sync(in_sync), .wr_count(wr_count),
    .cfg_mode(cfg_mode), .cfg_start_inc(cfg_start_inc),
    .cfg_start_phase(cfg_start_phase), .cfg_delta(cfg_delta),
    .cfg_half(cfg_half), .cfg_in_len(cfg_in_len),
    .issue(issue), .active(active), .rd_idx(rd_idx), .weight(weight),
    .cur_inc(cur_inc), .len_q(len_q), .mode_q(mode_q)
  );

  // Two identical copies of the line store: one read at i, one at i+1.
  genvar b;
  generate
    for (b = 0; b < 2; b++) begin : g_bank
      logic [AW-1:0] raddr;
      assign raddr = AW'(rd_idx + CNT_W'(b));
      hs_line_ram #(.DW(PW), .AW(AW)) u_ram (
        .clk(clk), .we(in_valid), .waddr(waddr), .wdata(in_pix),
        .raddr(raddr), .rdata(bank_q[b])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      rd_weight <= '0;
    end else begin
      rd_valid  <= issue;
      rd_weight <= weight;
    end
  end

  hs_lerp #(.DW(DW), .NCOMP(NCOMP)) u_lerp (
    .clk(clk), .rst(rst), .in_valid(rd_valid),
    .left_pix(bank_q[0]), .right_pix(bank_q[1]), .weight(rd_weight),
    .out_valid(out_valid), .out_pix(out_pix)
  );
endmodule

// File: rtl/hs_scaler_chk.sv
module hs_scaler_chk
  import hs_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int FRAC  = 16,
  parameter int INC_W = 19
) (
  input logic             clk,
  input logic             rst,
  input logic             in_sync,
  input logic             issue,
  input logic             active,
  input logic [CNT_W-1:0] rd_idx,
  input logic [CNT_W-1:0] wr_count,
  input logic [CNT_W-1:0] len_q,
  input logic [INC_W-1:0] cur_inc,
  input logic [1:0]       mode_q,
  input logic             out_valid
);
  localparam logic [INC_W-1:0] LO_INC = INC_W'(1 << (FRAC - 2));
  localparam logic [INC_W-1:0] HI_INC = INC_W'(4 << FRAC);

  AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> !out_valid); // R1

  AST_ISSUE_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
    issue |-> ({1'b0, wr_count} >= ({1'b0, rd_idx} + (CNT_W+1)'(2)))); // R7

  AST_ISSUE_BEFORE_END: assert property (@(posedge clk) disable iff (rst)
    issue |-> ({1'b0, rd_idx} + (CNT_W+1)'(1) < {1'b0, len_q})); // R3

  AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    active |-> (cur_inc >= LO_INC && cur_inc <= HI_INC)); // R6

  AST_OUT_PIPE_DELAY: assert property (@(posedge clk) disable iff (rst)
    issue |-> ##2 out_valid); // R2

  AST_IDX_NONDECREASING: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active) && !$past(in_sync)) |-> rd_idx >= $past(rd_idx)); // R2

  AST_UNIFORM_STEADY: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active) && !$past(in_sync) && mode_q != HS_WIDE && mode_q != HS_NARROW)
      |-> $stable(cur_inc)); // R9
endmodule

bind hs_scaler hs_scaler_chk #(.CNT_W(CNT_W), .FRAC(FRAC), .INC_W(INC_W)) u_chk (
  .clk(clk), .rst(rst), .in_sync(in_sync), .issue(issue), .active(active),
  .rd_idx(rd_idx), .wr_count(wr_count), .len_q(len_q), .cur_inc(cur_inc),
  .mode_q(mode_q), .out_valid(out_valid)
);

// File: tb/test_hs_scaler.sv
module test_hs_scaler;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [1:0]         cfg_mode = 2'd0;
  logic [18:0]        cfg_start_inc = 19'h10000;
  logic [15:0]        cfg_start_phase = '0;
  logic signed [15:0] cfg_delta = '0;
  logic [11:0]        cfg_half = '0;
  logic [11:0]        cfg_in_len = '0;
  logic               in_sync = 1'b0;
  logic               in_valid = 1'b0;
  logic [23:0]        in_pix = '0;
  logic               out_valid;
  logic [23:0]        out_pix;

  int checks = 0;
  int errors = 0;
  logic [23:0] pix [512];
  logic [23:0] got [$];
  logic [23:0] exp_q [$];

  always #5 clk = ~clk;

  hs_scaler i_hs_scaler (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_start_inc(cfg_start_inc),
    .cfg_start_phase(cfg_start_phase), .cfg_delta(cfg_delta), .cfg_half(cfg_half),
    .cfg_in_len(cfg_in_len), .in_sync(in_sync), .in_valid(in_valid), .in_pix(in_pix),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  always @(negedge clk) if (!rst && out_valid) got.push_back(out_pix);

  function automatic int clampi(input int v);
    if (v < 32'h4000)  return 32'h4000;
    if (v > 32'h40000) return 32'h40000;
    return v;
  endfunction

  task automatic fill(input int seed);
    for (int i = 0; i < 512; i++) begin
      pix[i][7:0]   = 8'((i * 7 + seed) & 255);
      pix[i][15:8]  = 8'((250 - i * 5 + seed) & 255);
      pix[i][23:16] = 8'((i * i + seed) & 255);
    end
  endtask

  // Expected output sequence computed from R2..R6, R9.
  task automatic model(input int mode, input int sinc, input int delta, input int half,
                       input int len, input int phase);
    longint acc = phase;
    int inc = clampi(sinc);
    int n = 0;
    while (int'(acc >>> 16) + 1 < len && n < 4000) begin
      int i = int'(acc >>> 16);
      int w = int'((acc >>> 10) & 63);
      logic [23:0] v;
      for (int k = 0; k < 3; k++) begin
        int a = int'(pix[i][k*8 +: 8]);
        int b = int'(pix[i+1][k*8 +: 8]);
        v[k*8 +: 8] = 8'((a * (64 - w) + b * w) >> 6);
      end
      exp_q.push_back(v);
      acc += inc;
      if (mode == 1)      inc = clampi(inc + ((n < half) ? delta : -delta));
      else if (mode == 2) inc = clampi(inc + ((n < half) ? -delta : delta));
      n++;
    end
  endtask

  task automatic send(input int count, input int gap);
    @(negedge clk); in_sync = 1'b1; in_valid = 1'b0;
    @(negedge clk); in_sync = 1'b0;
    for (int i = 0; i < count; i++) begin
      in_valid = 1'b1; in_pix = pix[i];
      @(negedge clk); in_valid = 1'b0;
      repeat (gap) @(negedge clk);
    end
    repeat (400) @(negedge clk);
  endtask

  task automatic check_num(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic compare(input string req);
    int n = (got.size() < exp_q.size()) ? got.size() : exp_q.size();
    check_num({req, " output count"}, got.size(), exp_q.size());
    for (int i = 0; i < n; i++) begin
      checks++;
      if (got[i] !== exp_q[i]) begin
        errors++;
        $display("FAIL %s pixel %0d actual %h expected %h", req, i, got[i], exp_q[i]);
      end
    end
  endtask

  task automatic run(input string req, input int mode, input int sinc, input int delta,
                     input int half, input int len, input int phase, input int gap, input int seed);
    fill(seed);
    cfg_mode = 2'(mode); cfg_start_inc = 19'(sinc); cfg_delta = 16'(delta);
    cfg_half = 12'(half); cfg_in_len = 12'(len); cfg_start_phase = 16'(phase);
    got.delete(); exp_q.delete();
    model(mode, sinc, delta, half, len, phase);
    send(len, gap);
    compare(req);
  endtask

  task automatic t_reset;
    int seen = 0;
    repeat (20) begin
      @(negedge clk);
      if (out_valid) seen++;
    end
    check_num("R1 out_valid after reset", seen, 0);
  endtask

  task automatic t_resync;
    fill(11);
    cfg_mode = 2'd0; cfg_start_inc = 19'h8000; cfg_delta = '0;
    cfg_half = '0; cfg_in_len = 12'd40; cfg_start_phase = '0;
    got.delete(); exp_q.delete();
    model(0, 32'h8000, 0, 0, 20, 0);
    send(20, 0);
    fill(77);
    model(0, 32'h8000, 0, 0, 40, 0);
    send(40, 0);
    compare("R8 resync");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    run("R2 unit step",          0, 32'h10000, 0, 0, 32, 0, 0, 3);
    run("R2 half step phase",    0, 32'h8000, 0, 0, 24, 32'h8000, 0, 9);
    run("R3 quarter decimation", 0, 32'h40000, 0, 0, 50, 32'h1234, 0, 5);
    run("R10 ratio 1.5",         0, 32'hAAAB, 0, 0, 41, 0, 0, 1);
    check_num("R10 count for 1.5", got.size(), 60);
    run("R10 ratio 1.25",        0, 32'hCCCD, 0, 0, 41, 0, 0, 2);
    check_num("R10 count for 1.25", got.size(), 50);
    run("R4 widescreen fill",    1, 32'hC000, 32'h200, 30, 64, 0, 0, 4);
    run("R5 narrow fill",        2, 32'h18000, 32'h300, 20, 64, 0, 0, 6);
    run("R6 clamp both limits",  1, 32'h2000, 32'h4000, 15, 60, 0, 0, 8);
    run("R6 narrow clamp",       2, 32'h50000, 32'h6000, 10, 80, 0, 0, 12);
    run("R9 reserved mode",      3, 32'h9000, 32'h700, 10, 30, 0, 0, 13);
    run("R7 paced input",        0, 32'h4000, 0, 0, 40, 0, 3, 14);
    run("R7 paced widescreen",   1, 32'h8000, 32'h100, 25, 40, 32'h4000, 2, 15);
    t_resync();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule